// File: doc/BRIEF.md
# Partial-Array Temperature-Aware Refresh Controller

This block decides when a pseudo-static memory refreshes its DRAM rows while the memory is idle. It watches the chip-enable, a transaction-busy flag and a snapshot of the address and control pins to decide when the device is in standby. While the device is in standby, it issues single-cycle row-refresh requests with a row address. The time between requests depends on a two-bit temperature-ceiling setting. A three-bit partition field and an anchor bit limit the refreshed rows to part of the array, which can sit at the low end or the high end of the row space.

A deep power-down setting stops every refresh request. When deep power-down is released, the controller enters an initialization phase. This phase lasts a fixed number of clock cycles, derived from the clock frequency and a wait time in microseconds. Normal operation, shown by `ready`, resumes only when that phase ends. The cell array and the read/write datapath are outside this block.

Top module: `partial_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low, `rf_req` and `standby` are 0, `ready` is 1, and `dpd_active` and `init_busy` are 0.
- R2: `standby` is 1 one cycle after a clock edge that samples `chip_en_n` high and `xfer_busy` low. While `chip_en_n` is low or `xfer_busy` is high, and `bus_snap` keeps changing, `standby` is 0.
- R3: With `chip_en_n` low, `standby` rises after `bus_snap` has held one value for IDLE_CYC+1 clock edges. It is still 0 after IDLE_CYC-1 edges. It falls one edge after `bus_snap` changes.
- R4: `rf_req` is raised only while `ready` is 1, and only when the cycle before was in standby.
- R5: In continuous standby, `rf_req` is a one-cycle pulse. Pulses are spaced IV_15C, IV_45C, IV_70C or IV_85C cycles apart for `cfg_temp` codes 00, 01, 10 and 11. The 85-degree ceiling by default refreshes four times as often as the 15-degree one.
- R6: `cfg_part` selects the refreshed slice: 000 full, 101 three quarters, 001 one half, 010 one quarter. Successive `rf_row` values step upward by one and wrap within the slice.
- R7: With `cfg_anchor` 0, the slice starts at row 0. With `cfg_anchor` 1, it ends at row ROWS-1.
- R8: With `cfg_part` = 100 (empty slice), no `rf_req` is issued.
- R9: One edge after `cfg_dpd` is sampled high, `dpd_active` is 1. While it is 1, no `rf_req` is issued.
- R10: After `cfg_dpd` is sampled low in deep power-down, `init_busy` stays 1 for exactly CLK_MHZ*INIT_US cycles. Then `ready` returns to 1 and refresh resumes. Exactly one of `ready`, `dpd_active` and `init_busy` is 1 at any time.
- R11: The unused partition codes 011, 110 and 111 refresh the full array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_part | input | 3 | Refreshed-slice size code |
| cfg_anchor | input | 1 | Slice anchor: 0 low end, 1 high end |
| cfg_temp | input | 2 | Temperature ceiling code |
| cfg_dpd | input | 1 | Deep power-down request |
| chip_en_n | input | 1 | Chip enable, active low |
| xfer_busy | input | 1 | A read or write is in progress |
| bus_snap | input | BUS_W | Address and control pin snapshot |
| rf_req | output | 1 | Row-refresh request pulse |
| rf_row | output | ROW_W | Row to refresh, valid with `rf_req` |
| standby | output | 1 | Device is in standby |
| dpd_active | output | 1 | Deep power-down in effect |
| init_busy | output | 1 | Post-power-down initialization running |
| ready | output | 1 | Normal operation allowed |

## Verification
The bench builds the block with 16 rows, an 8-bit pin snapshot, an 8-cycle static-idle limit and refresh intervals of 40, 30, 20 and 10 cycles. The initialization wait is 2 MHz times 5 us, which gives 10 cycles. With these values the bench can walk every slice through its wrap point several times in a few hundred cycles. It can also time the full initialization phase and measure each temperature spacing exactly. The static-idle boundary can be probed one cycle on either side.

// File: rtl/prc_pkg.sv
// prc_pkg: shared codes and helpers for the partial refresh controller.
// Assumes the row count is a multiple of four.
package prc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_DPD  = 2'd1,
        MODE_INIT = 2'd2
    } prc_mode_e;

    localparam logic [2:0] PART_FULL    = 3'b000;
    localparam logic [2:0] PART_HALF    = 3'b001;
    localparam logic [2:0] PART_QUARTER = 3'b010;
    localparam logic [2:0] PART_NONE    = 3'b100;
    localparam logic [2:0] PART_3Q      = 3'b101;

    // Number of rows in the slice chosen by a partition code.
    function automatic int unsigned part_rows(logic [2:0] code, int unsigned rows);
        case (code)
            PART_3Q:      return (rows / 4) * 3;
            PART_HALF:    return rows / 2;
            PART_QUARTER: return rows / 4;
            PART_NONE:    return 0;
            default:      return rows;
        endcase
    endfunction

endpackage

// File: rtl/prc_standby_det.sv
// prc_standby_det: flags standby when the chip is deselected with no
// transfer in progress, or when the pin snapshot has held still for
// IDLE_CYC cycles. Output is registered.
module prc_standby_det #(
    parameter int BUS_W    = 24,
    parameter int IDLE_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en_n,
    input  logic             xfer_busy,
    input  logic [BUS_W-1:0] bus_snap,
    output logic             standby
);
    localparam int IW = $clog2(IDLE_CYC + 1);

    logic [BUS_W-1:0] snap_q;
    logic [IW-1:0]    still_cnt;
    logic             changed;
    logic             still_hit;

    assign changed   = (bus_snap != snap_q);
    assign still_hit = !changed && (still_cnt == IW'(IDLE_CYC));

    // Track how long the pins have held still and register the standby flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q    <= '0;
            still_cnt <= '0;
            standby   <= 1'b0;
        end else begin
            snap_q <= bus_snap;
            if (changed)
                still_cnt <= '0;
            else if (still_cnt != IW'(IDLE_CYC))
                still_cnt <= still_cnt + 1'b1;
            standby <= (chip_en_n && !xfer_busy) || still_hit;
        end
    end
endmodule

// File: rtl/prc_mode_seq.sv
// prc_mode_seq: run / deep power-down / initialization sequencer.
// Leaving deep power-down starts an INIT_CYC-cycle wait before run mode.
// Assumes INIT_CYC >= 1.
module prc_mode_seq #(
    parameter int INIT_CYC = 30000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_dpd,
    output prc_pkg::prc_mode_e mode
);
    import prc_pkg::*;
    localparam int CW = $clog2(INIT_CYC + 1);

    logic [CW-1:0] wait_cnt;

    // Step the mode and the initialization countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_RUN;
            wait_cnt <= '0;
        end else begin
            case (mode)
                MODE_RUN:  if (cfg_dpd) mode <= MODE_DPD;
                MODE_DPD:  if (!cfg_dpd) begin
                               mode     <= MODE_INIT;
                               wait_cnt <= CW'(INIT_CYC - 1);
                           end
                MODE_INIT: if (cfg_dpd) mode <= MODE_DPD;
                           else if (wait_cnt == '0) mode <= MODE_RUN;
                           else wait_cnt <= wait_cnt - 1'b1;
                default:   mode <= MODE_RUN;
            endcase
        end
    end
endmodule

// File: rtl/prc_interval_timer.sv
// prc_interval_timer: counts enabled cycles and raises a combinational fire
// strobe once per interval. The interval is chosen by the temperature code.
// The count clears whenever the timer is disabled.
module prc_interval_timer #(
    parameter int IV_15C = 6240,
    parameter int IV_45C = 4680,
    parameter int IV_70C = 3120,
    parameter int IV_85C = 1560
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] cfg_temp,
    output logic       fire
);
    localparam int MAXIV = (IV_15C > IV_45C) ?
                           ((IV_15C > IV_70C) ? ((IV_15C > IV_85C) ? IV_15C : IV_85C)
                                              : ((IV_70C > IV_85C) ? IV_70C : IV_85C))
                         : ((IV_45C > IV_70C) ? ((IV_45C > IV_85C) ? IV_45C : IV_85C)
                                              : ((IV_70C > IV_85C) ? IV_70C : IV_85C));
    localparam int CW = $clog2(MAXIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Last count value of the selected interval.
    always_comb begin
        case (cfg_temp)
            2'b00:   last = CW'(IV_15C - 1);
            2'b01:   last = CW'(IV_45C - 1);
            2'b10:   last = CW'(IV_70C - 1);
            default: last = CW'(IV_85C - 1);
        endcase
    end

    assign fire = en && (cnt >= last);

    // Advance the interval count while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || fire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/prc_row_sched.sv
// prc_row_sched: registers the refresh request and picks the next row
// inside the selected slice. The slice offset wraps at the slice size.
// A stale offset that falls outside a shrunken slice restarts at zero.
module prc_row_sched #(
    parameter int ROWS = 8192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [2:0]              cfg_part,
    input  logic                    cfg_anchor,
    output logic                    rf_req,
    output logic [$clog2(ROWS)-1:0] rf_row
);
    localparam int ROW_W = $clog2(ROWS);

    logic [ROW_W:0]   part_sz;
    logic [ROW_W:0]   base;
    logic [ROW_W-1:0] off;
    logic [ROW_W-1:0] eff_off;
    logic [ROW_W:0]   off_inc;
    logic [ROW_W:0]   row_sum;

    // Slice geometry and the row for this request.
    always_comb begin
        part_sz = (ROW_W + 1)'(prc_pkg::part_rows(cfg_part, ROWS));
        base    = cfg_anchor ? ((ROW_W + 1)'(ROWS) - part_sz) : '0;
        eff_off = ({1'b0, off} < part_sz) ? off : '0;
        off_inc = {1'b0, eff_off} + 1'b1;
        row_sum = base + {1'b0, eff_off};
    end

    // Register the request and advance the slice offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_req <= 1'b0;
            rf_row <= '0;
            off    <= '0;
        end else begin
            rf_req <= fire;
            if (fire) begin
                rf_row <= row_sum[ROW_W-1:0];
                off    <= (off_inc >= part_sz) ? '0 : off_inc[ROW_W-1:0];
            end
        end
    end
endmodule

// File: rtl/partial_refresh_ctrl.sv
// partial_refresh_ctrl: top level. Refresh runs only in run mode, in standby,
// with a non-empty slice, and with no power-down request pending.
// Assumes ROWS is a power of two and a multiple of four.
module partial_refresh_ctrl #(
    parameter int ROWS     = 8192,
    parameter int BUS_W    = 24,
    parameter int IDLE_CYC = 2000,
    parameter int IV_15C   = 6240,
    parameter int IV_45C   = 4680,
    parameter int IV_70C   = 3120,
    parameter int IV_85C   = 1560,
    parameter int CLK_MHZ  = 200,
    parameter int INIT_US  = 150
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cfg_part,
    input  logic                    cfg_anchor,
    input  logic [1:0]              cfg_temp,
    input  logic                    cfg_dpd,
    input  logic                    chip_en_n,
    input  logic                    xfer_busy,
    input  logic [BUS_W-1:0]        bus_snap,
    output logic                    rf_req,
    output logic [$clog2(ROWS)-1:0] rf_row,
    output logic                    standby,
    output logic                    dpd_active,
    output logic                    init_busy,
    output logic                    ready
);
    import prc_pkg::*;
    localparam int INIT_CYC = CLK_MHZ * INIT_US;

    prc_mode_e mode;
    logic      tmr_en;
    logic      fire;

    prc_standby_det #(.BUS_W(BUS_W), .IDLE_CYC(IDLE_CYC)) u_sby (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n),
        .xfer_busy(xfer_busy), .bus_snap(bus_snap), .standby(standby)
    );

    prc_mode_seq #(.INIT_CYC(INIT_CYC)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_dpd(cfg_dpd), .mode(mode)
    );

    // Gate the interval timer on mode, standby and a non-empty slice.
    always_comb begin
        tmr_en = (mode == MODE_RUN) && !cfg_dpd && standby && (cfg_part != PART_NONE);
    end

    prc_interval_timer #(.IV_15C(IV_15C), .IV_45C(IV_45C),
                         .IV_70C(IV_70C), .IV_85C(IV_85C)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .cfg_temp(cfg_temp), .fire(fire)
    );

    prc_row_sched #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .fire(fire), .cfg_part(cfg_part),
        .cfg_anchor(cfg_anchor), .rf_req(rf_req), .rf_row(rf_row)
    );

    assign dpd_active = (mode == MODE_DPD);
    assign init_busy  = (mode == MODE_INIT);
    assign ready      = (mode == MODE_RUN);
endmodule

// File: rtl/prc_checker.sv
// prc_checker: temporal properties of the refresh controller, bound to the top.
module prc_checker #(
    parameter int ROWS = 8192
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              cfg_part,
    input logic                    cfg_anchor,
    input logic                    rf_req,
    input logic [$clog2(ROWS)-1:0] rf_row,
    input logic                    dpd_active,
    input logic                    init_busy,
    input logic                    ready
);
    int unsigned sz;
    int unsigned lo;

    // Expected slice bounds from the current configuration.
    always_comb begin
        sz = prc_pkg::part_rows(cfg_part, ROWS);
        lo = cfg_anchor ? (ROWS - sz) : 0;
    end

    AST_REQ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> ready); // R4
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |=> !rf_req); // R5
    AST_ROW_IN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && $stable(cfg_part) && $stable(cfg_anchor))
        |-> (int'(rf_row) >= int'(lo) && int'(rf_row) < int'(lo + sz))); // R6
    AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> ($past(cfg_part) != 3'b100)); // R8
    AST_DPD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_active |-> !rf_req); // R9
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dpd_active, init_busy, ready}) == 1); // R10
    AST_INIT_AFTER_DPD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dpd_active) && !$past(!rst_n)) |-> init_busy); // R10
endmodule

bind partial_refresh_ctrl prc_checker #(.ROWS(ROWS)) u_prc_chk (
    .clk(clk), .rst_n(rst_n), .cfg_part(cfg_part), .cfg_anchor(cfg_anchor),
    .rf_req(rf_req), .rf_row(rf_row), .dpd_active(dpd_active),
    .init_busy(init_busy), .ready(ready)
);

// File: tb/partial_refresh_ctrl_bench.sv
// Directed bench for partial_refresh_ctrl: one task per scenario.
module partial_refresh_ctrl_bench;
    localparam int ROWS = 16, ROW_W = 4, BUS_W = 8, IDLE = 8;
    localparam int IV0 = 40, IV1 = 30, IV2 = 20, IV3 = 10;
    localparam int INIT_CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_part = 3'b000;
    logic cfg_anchor = 1'b0;
    logic [1:0] cfg_temp = 2'b11;
    logic cfg_dpd = 1'b0;
    logic chip_en_n = 1'b1;
    logic xfer_busy = 1'b0;
    logic [BUS_W-1:0] bus_snap = '0;
    logic rf_req;
    logic [ROW_W-1:0] rf_row;
    logic standby, dpd_active, init_busy, ready;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    partial_refresh_ctrl #(.ROWS(ROWS), .BUS_W(BUS_W), .IDLE_CYC(IDLE),
        .IV_15C(IV0), .IV_45C(IV1), .IV_70C(IV2), .IV_85C(IV3),
        .CLK_MHZ(2), .INIT_US(5)) u_partial_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_part(cfg_part), .cfg_anchor(cfg_anchor),
        .cfg_temp(cfg_temp), .cfg_dpd(cfg_dpd), .chip_en_n(chip_en_n),
        .xfer_busy(xfer_busy), .bus_snap(bus_snap), .rf_req(rf_req),
        .rf_row(rf_row), .standby(standby), .dpd_active(dpd_active),
        .init_busy(init_busy), .ready(ready));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for the next request, sampled at the falling edge.
    task automatic wait_req(output int gap, output int row);
        gap = 0;
        row = -1;
        forever begin
            @(negedge clk);
            gap++;
            if (rf_req) begin row = int'(rf_row); return; end
            if (gap > 200) begin gap = -1; return; end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rf_req == 0 && standby == 0, "R1 req/standby", {rf_req, standby}, 0);
        chk(ready == 1 && dpd_active == 0 && init_busy == 0, "R1 mode",
            {ready, dpd_active, init_busy}, 4);
        rst_n = 1'b1;
    endtask

    task automatic t_standby_ce();
        chip_en_n = 1'b0; bus_snap++;
        @(negedge clk);
        chk(standby == 0, "R2 selected", standby, 0);
        chip_en_n = 1'b1; xfer_busy = 1'b1;
        for (int i = 0; i < 4; i++) begin
            bus_snap++;
            @(negedge clk);
            chk(standby == 0, "R2 busy", standby, 0);
        end
        xfer_busy = 1'b0; bus_snap++;
        @(negedge clk);
        chk(standby == 1, "R2 idle deselect", standby, 1);
    endtask

    task automatic t_standby_static();
        chip_en_n = 1'b0; bus_snap++;
        repeat (IDLE - 1) @(negedge clk);
        chk(standby == 0, "R3 before limit", standby, 0);
        repeat (3) @(negedge clk);
        chk(standby == 1, "R3 after limit", standby, 1);
        bus_snap++;
        @(negedge clk);
        chk(standby == 0, "R3 change clears", standby, 0);
        chip_en_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_interval(input logic [1:0] code, input int iv);
        int g, r;
        cfg_temp = code;
        wait_req(g, r);
        wait_req(g, r);
        chk(g == iv, $sformatf("R5 spacing code %0d", code), g, iv);
        @(negedge clk);
        chk(rf_req == 0, "R5 single pulse", rf_req, 0);
        chk(ready == 1, "R4 ready with req", ready, 1);
    endtask

    task automatic t_slice(input logic [2:0] code, input logic anc, input int sz,
                           input string req);
        int g, r, prev, lo, hi, exp;
        cfg_part = code; cfg_anchor = anc; cfg_temp = 2'b11;
        lo = anc ? ROWS - sz : 0;
        hi = lo + sz - 1;
        wait_req(g, prev);
        chk(prev >= lo && prev <= hi, {req, " first in slice"}, prev, lo);
        for (int i = 0; i < sz + 2; i++) begin
            wait_req(g, r);
            exp = (prev == hi) ? lo : prev + 1;
            chk(r == exp, {req, " row step"}, r, exp);
            prev = r;
        end
    endtask

    task automatic t_none();
        int n = 0;
        cfg_part = 3'b100;
        repeat (100) begin @(negedge clk); if (rf_req) n++; end
        chk(n == 0, "R8 empty slice", n, 0);
        cfg_part = 3'b000;
    endtask

    task automatic t_dpd_init();
        int n = 0;
        int g, r;
        cfg_dpd = 1'b1;
        @(negedge clk);
        chk(dpd_active == 1, "R9 enter", dpd_active, 1);
        repeat (60) begin @(negedge clk); if (rf_req) n++; end
        chk(n == 0, "R9 no refresh", n, 0);
        cfg_dpd = 1'b0;
        n = 0;
        for (int i = 0; i < INIT_CYC; i++) begin
            @(negedge clk);
            if (init_busy && !ready) n++;
        end
        chk(n == INIT_CYC, "R10 init length", n, INIT_CYC);
        @(negedge clk);
        chk(ready == 1 && init_busy == 0, "R10 ready after init", ready, 1);
        wait_req(g, r);
        chk(g > 0, "R10 refresh resumes", g, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_standby_ce();
        t_standby_static();
        t_interval(2'b00, IV0);
        t_interval(2'b01, IV1);
        t_interval(2'b10, IV2);
        t_interval(2'b11, IV3);
        t_slice(3'b000, 1'b0, 16, "R6 full");
        t_slice(3'b101, 1'b0, 12, "R6 3/4");
        t_slice(3'b001, 1'b0, 8, "R6 half");
        t_slice(3'b010, 1'b0, 4, "R6 quarter");
        t_slice(3'b010, 1'b1, 4, "R7 top quarter");
        t_slice(3'b101, 1'b1, 12, "R7 top 3/4");
        t_slice(3'b110, 1'b0, 16, "R11 reserved");
        t_none();
        t_dpd_init();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule